// File: doc/BRIEF.md
# MLC Page Read Sequencer

This block sequences the read of one wordline of two-bit-per-cell flash. A request names which of the two pages stored on the wordline is wanted. The block then sets the reference-voltage code for the sense array and raises a sense strobe. It collects the per-cell conduct results and merges them into the page bits. The lower page needs one sense. The upper page needs two.

Each reference is not a fixed value. The applied code is the nominal code for that reference plus a signed per-block correction, which comes from a retention-shift predictor outside the block. The block clamps this sum to the range of the reference DAC. The corrections and the page selection are latched when the request is accepted. The predictor is therefore free to move on to the next block while the read is still running.

The cell states, from lowest to highest threshold, are erased, P1, P2 and P3. Their two-bit codes are 11, 10, 00 and 01, written as (lower-page bit, upper-page bit). Three references Va < Vb < Vc separate neighbouring states.

Top module: `mlc_page_read_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `sense_strobe` and `done` are low and `page_bits` is all zeros.
- R2: A lower-page request (`req_upper`=0) causes exactly one sense, at the Vb reference. Each page bit equals the sensed bit of its cell, where 1 means the cell conducted. The result is 1 for erased and P1 cells and 0 for P2 and P3 cells.
- R3: An upper-page request (`req_upper`=1) causes exactly two senses, the Va reference first and the Vc reference second. A page bit is 1 when the cell conducted at Va or did not conduct at Vc, and 0 otherwise.
- R4: The applied code for a reference is its nominal parameter value plus the matching two's-complement correction input of OFS_W bits (`ofs_a`, `ofs_b` or `ofs_c`).
- R5: The adjusted code saturates. A sum below 0 gives 0, and a sum above 2^DAC_W-1 gives 2^DAC_W-1. The code never wraps.
- R6: The corrections and the page selection are sampled in the cycle the request is accepted. Later changes to those inputs have no effect on the running read.
- R7: A request raised while `busy` is high is ignored. It starts no sense after the current read completes.
- R8: `done` is a one-cycle pulse in the cycle that `page_bits` takes its new value. `page_bits` changes at no other time.
- R9: Once raised, `sense_strobe` stays high until `sense_valid` is seen. `ref_code` does not change while the strobe is high.
- R10: Between accepting a request and raising `done`, the block passes through a reference set-up cycle before each sense and one merge cycle after the last sense. The page therefore appears two cycles after the last `sense_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request, accepted when idle |
| req_upper | input | 1 | Page select: 0 lower page, 1 upper page |
| ofs_a | input | OFS_W | Signed correction for the Va reference |
| ofs_b | input | OFS_W | Signed correction for the Vb reference |
| ofs_c | input | OFS_W | Signed correction for the Vc reference |
| ref_code | output | DAC_W | Reference-voltage DAC code |
| sense_strobe | output | 1 | Sense request to the cell array |
| sense_valid | input | 1 | Sense result present on sense_bits |
| sense_bits | input | NCELL | Per-cell result, 1 means the cell conducted |
| busy | output | 1 | A read is in progress |
| done | output | 1 | Page result valid pulse |
| page_bits | output | NCELL | Decoded page bits |

## Verification
The bench uses the defaults: eight cells, a six-bit DAC, five-bit corrections, and nominal codes 12, 32 and 52. With five-bit corrections the Vc code can be pushed past 63 and the Va code below zero, so both clamp ends are exercised, and the Vb code can be moved by the full correction span. A bench model of the sense array turns per-cell threshold codes into conduct bits. This lets each threshold state be placed on either side of a shifted reference, for both pages.

// File: rtl/mlcrd_pkg.sv
package mlcrd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SET_REF,
      ST_SENSE,
      ST_COMBINE,
      ST_DONE
   } rd_state_e;

   // index of the reference a sense step uses
   localparam int unsigned REF_LO  = 0;
   localparam int unsigned REF_MID = 1;
   localparam int unsigned REF_HI  = 2;
   localparam int unsigned NREF    = 3;
endpackage

// File: rtl/ref_adjust.sv
module ref_adjust #(
   parameter int DAC_W = 6,
   parameter int OFS_W = 5,
   parameter int NOM   = 32
) (
   input  logic signed [OFS_W-1:0] ofs,
   output logic [DAC_W-1:0]        code
);
   localparam int SUM_W = ((DAC_W > OFS_W) ? DAC_W : OFS_W) + 2;
   localparam int CODE_MAX = (1 << DAC_W) - 1;

   logic signed [SUM_W-1:0] nom_s;
   logic signed [SUM_W-1:0] ofs_s;
   logic signed [SUM_W-1:0] sum;
   logic signed [SUM_W-1:0] max_s;

   always_comb begin
      nom_s = SUM_W'(NOM);
      max_s = SUM_W'(CODE_MAX);
      ofs_s = {{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs};
      sum   = nom_s + ofs_s;
      if (sum < 0)
         code = '0;
      else if (sum > max_s)
         code = DAC_W'(CODE_MAX);
      else
         code = sum[DAC_W-1:0];
   end
endmodule

// File: rtl/sense_combine.sv
module sense_combine #(
   parameter int NCELL = 8
) (
   input  logic             upper,
   input  logic [NCELL-1:0] first_s,
   input  logic [NCELL-1:0] second_s,
   output logic [NCELL-1:0] page
);
   for (genvar c = 0; c < NCELL; c++) begin : g_cell
      always_comb begin
         if (upper)
            page[c] = first_s[c] | ~second_s[c];
         else
            page[c] = first_s[c];
      end
   end
endmodule

// File: rtl/rd_fsm.sv
module rd_fsm
   import mlcrd_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_valid,
   input  logic      req_upper,
   input  logic      sense_valid,
   output rd_state_e state,
   output logic      upper_q,
   output logic [1:0] ref_sel,
   output logic      load_req,
   output logic      cap_first,
   output logic      cap_second,
   output logic      page_load
);
   logic step_q;

   assign load_req   = (state == ST_IDLE) && req_valid;
   assign cap_first  = (state == ST_SENSE) && sense_valid && !step_q;
   assign cap_second = (state == ST_SENSE) && sense_valid && step_q;
   assign page_load  = (state == ST_COMBINE);

   always_comb begin
      if (!upper_q)
         ref_sel = 2'(REF_MID);
      else if (!step_q)
         ref_sel = 2'(REF_LO);
      else
         ref_sel = 2'(REF_HI);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         upper_q <= 1'b0;
         step_q  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  upper_q <= req_upper;
                  step_q  <= 1'b0;
                  state   <= ST_SET_REF;
               end
            end
            ST_SET_REF: state <= ST_SENSE;
            ST_SENSE: begin
               if (sense_valid) begin
                  if (upper_q && !step_q) begin
                     step_q <= 1'b1;
                     state  <= ST_SET_REF;
                  end else begin
                     state <= ST_COMBINE;
                  end
               end
            end
            ST_COMBINE: state <= ST_DONE;
            ST_DONE:    state <= ST_IDLE;
            default:    state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mlc_page_read_seq.sv
module mlc_page_read_seq
   import mlcrd_pkg::*;
#(
   parameter int NCELL  = 8,
   parameter int DAC_W  = 6,
   parameter int OFS_W  = 5,
   parameter int VA_NOM = 12,
   parameter int VB_NOM = 32,
   parameter int VC_NOM = 52
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic                    req_upper,
   input  logic signed [OFS_W-1:0] ofs_a,
   input  logic signed [OFS_W-1:0] ofs_b,
   input  logic signed [OFS_W-1:0] ofs_c,
   output logic [DAC_W-1:0]        ref_code,
   output logic                    sense_strobe,
   input  logic                    sense_valid,
   input  logic [NCELL-1:0]        sense_bits,
   output logic                    busy,
   output logic                    done,
   output logic [NCELL-1:0]        page_bits
);
   localparam int CODE_MAX = (1 << DAC_W) - 1;

   if (!(VA_NOM < VB_NOM && VB_NOM < VC_NOM))
      $error("nominal references must rise: Va < Vb < Vc");
   if (VA_NOM < 0 || VC_NOM > CODE_MAX)
      $error("nominal references must fit the DAC range");
   if (OFS_W < 2 || OFS_W > DAC_W + 1)
      $error("correction width out of supported range");
   if (NCELL < 1)
      $error("at least one cell is required");

   rd_state_e         state;
   logic              upper_q;
   logic [1:0]        ref_sel;
   logic              load_req;
   logic              cap_first;
   logic              cap_second;
   logic              page_load;
   logic signed [OFS_W-1:0] ofs_q [NREF];
   logic [DAC_W-1:0]  adj [NREF];
   logic [NCELL-1:0]  first_q;
   logic [NCELL-1:0]  second_q;
   logic [NCELL-1:0]  page_next;

   rd_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_upper  (req_upper),
      .sense_valid(sense_valid),
      .state      (state),
      .upper_q    (upper_q),
      .ref_sel    (ref_sel),
      .load_req   (load_req),
      .cap_first  (cap_first),
      .cap_second (cap_second),
      .page_load  (page_load)
   );

   for (genvar g = 0; g < NREF; g++) begin : g_ref
      ref_adjust #(
         .DAC_W(DAC_W),
         .OFS_W(OFS_W),
         .NOM  ((g == 0) ? VA_NOM : ((g == 1) ? VB_NOM : VC_NOM))
      ) u_adj (
         .ofs (ofs_q[g]),
         .code(adj[g])
      );
   end

   sense_combine #(.NCELL(NCELL)) u_comb (
      .upper   (upper_q),
      .first_s (first_q),
      .second_s(second_q),
      .page    (page_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NREF; r++) ofs_q[r] <= '0;
         first_q   <= '0;
         second_q  <= '0;
         page_bits <= '0;
      end else begin
         if (load_req) begin
            ofs_q[REF_LO]  <= ofs_a;
            ofs_q[REF_MID] <= ofs_b;
            ofs_q[REF_HI]  <= ofs_c;
         end
         if (cap_first)  first_q   <= sense_bits;
         if (cap_second) second_q  <= sense_bits;
         if (page_load)  page_bits <= page_next;
      end
   end

   assign ref_code     = adj[ref_sel];
   assign sense_strobe = (state == ST_SENSE);
   assign busy         = (state != ST_IDLE);
   assign done         = (state == ST_DONE);
endmodule

// File: rtl/mlc_page_read_chk.sv
module mlc_page_read_chk #(
   parameter int NCELL = 8,
   parameter int DAC_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             sense_valid,
   input logic             sense_strobe,
   input logic [DAC_W-1:0] ref_code,
   input logic             busy,
   input logic             done,
   input logic [NCELL-1:0] page_bits
);
   // R9
   ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sense_strobe && $past(sense_strobe) |-> $stable(ref_code));

   // R9
   strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sense_strobe && !sense_valid |=> sense_strobe);

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   page_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(page_bits) |-> done);

   // R7
   accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !busy |=> busy && !done);

   // R10
   strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_strobe || done) |-> busy);
endmodule

bind mlc_page_read_seq mlc_page_read_chk #(.NCELL(NCELL), .DAC_W(DAC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .sense_valid (sense_valid),
   .sense_strobe(sense_strobe),
   .ref_code    (ref_code),
   .busy        (busy),
   .done        (done),
   .page_bits   (page_bits)
);

// File: tb/sim_mlc_page_read_seq.sv
module sim_mlc_page_read_seq;
   localparam int NCELL = 8;
   localparam int DAC_W = 6;
   localparam int OFS_W = 5;
   localparam int VA = 12;
   localparam int VB = 32;
   localparam int VC = 52;
   localparam int CMAX = (1 << DAC_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_upper = 1'b0;
   logic signed [OFS_W-1:0] ofs_a = '0;
   logic signed [OFS_W-1:0] ofs_b = '0;
   logic signed [OFS_W-1:0] ofs_c = '0;
   logic [DAC_W-1:0] ref_code;
   logic sense_strobe;
   logic sense_valid = 1'b0;
   logic [NCELL-1:0] sense_bits = '0;
   logic busy;
   logic done;
   logic [NCELL-1:0] page_bits;

   int checks = 0;
   int fails = 0;
   int vth [NCELL];

   always #4 clk = ~clk;

   mlc_page_read_seq #(
      .NCELL(NCELL), .DAC_W(DAC_W), .OFS_W(OFS_W),
      .VA_NOM(VA), .VB_NOM(VB), .VC_NOM(VC)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_upper(req_upper),
      .ofs_a(ofs_a), .ofs_b(ofs_b), .ofs_c(ofs_c), .ref_code(ref_code),
      .sense_strobe(sense_strobe), .sense_valid(sense_valid),
      .sense_bits(sense_bits), .busy(busy), .done(done), .page_bits(page_bits)
   );

   task automatic check(input logic ok, input string rq, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   function automatic int clampc(input int v);
      if (v < 0) return 0;
      if (v > CMAX) return CMAX;
      return v;
   endfunction

   function automatic logic [NCELL-1:0] array_sense(input int r);
      logic [NCELL-1:0] b;
      for (int i = 0; i < NCELL; i++) b[i] = (r > vth[i]);
      return b;
   endfunction

   task automatic set_vth(input int shift);
      // erased, P1, P2, P3 placed twice with varied margins
      vth[0] = 5 + shift;  vth[1] = 20 + shift; vth[2] = 40 + shift; vth[3] = 60 + shift;
      vth[4] = 8 + shift;  vth[5] = 25 + shift; vth[6] = 45 + shift; vth[7] = 57 + shift;
   endtask

   task automatic wait_strobe(input string rq, output logic seen);
      seen = 1'b0;
      for (int t = 0; t < 40 && !seen; t++) begin
         @(negedge clk);
         if (sense_strobe) seen = 1'b1;
      end
      check(seen, rq, "strobe seen", int'(seen), 1);
   endtask

   // one full read; disturb changes inputs and raises a request mid-read
   task automatic run_read(input logic upper, input int oa, input int ob, input int oc,
                           input logic disturb, input string rq);
      logic [NCELL-1:0] s0 = '0;
      logic [NCELL-1:0] s1 = '0;
      logic [NCELL-1:0] expp;
      logic [NCELL-1:0] old_page;
      logic seen;
      int nsteps = upper ? 2 : 1;
      int exp_ref;
      int ref0;
      @(negedge clk);
      req_valid = 1'b1; req_upper = upper;
      ofs_a = OFS_W'(oa); ofs_b = OFS_W'(ob); ofs_c = OFS_W'(oc);
      @(negedge clk);
      req_valid = 1'b0;
      if (disturb) begin
         req_upper = ~upper; ofs_a = 5'sd7; ofs_b = -5'sd7; ofs_c = 5'sd3;
      end
      old_page = page_bits;
      for (int k = 0; k < nsteps; k++) begin
         wait_strobe(rq, seen);
         if (!seen) return;
         exp_ref = upper ? ((k == 0) ? clampc(VA + oa) : clampc(VC + oc)) : clampc(VB + ob);
         check(int'(ref_code) == exp_ref, rq, "ref code", int'(ref_code), exp_ref);
         ref0 = int'(ref_code);
         // R9: hold off the response and look for strobe and code to stay put
         @(negedge clk);
         @(negedge clk);
         check(sense_strobe == 1'b1, "R9", "strobe held", int'(sense_strobe), 1);
         check(int'(ref_code) == ref0, "R9", "code stable", int'(ref_code), ref0);
         if (disturb) req_valid = 1'b1;
         if (k == 0) s0 = array_sense(int'(ref_code));
         else        s1 = array_sense(int'(ref_code));
         sense_bits  = (k == 0) ? s0 : s1;
         sense_valid = 1'b1;
         @(negedge clk);
         sense_valid = 1'b0;
         req_valid   = 1'b0;
         if (k + 1 < nsteps)
            check(sense_strobe == 1'b0, "R10", "set-up gap", int'(sense_strobe), 0);
      end
      expp = upper ? (s0 | ~s1) : s0;
      // R10: merge cycle, then done
      check(done == 1'b0, "R10", "merge cycle done", int'(done), 0);
      check(page_bits == old_page, "R8", "page held", int'(page_bits), int'(old_page));
      @(negedge clk);
      check(done == 1'b1, "R10", "done timing", int'(done), 1);
      check(page_bits == expp, rq, "page bits", int'(page_bits), int'(expp));
      @(negedge clk);
      check(done == 1'b0, "R8", "done one cycle", int'(done), 0);
      check(page_bits == expp, "R8", "page kept", int'(page_bits), int'(expp));
      // R7: nothing further starts
      for (int t = 0; t < 4; t++) begin
         @(negedge clk);
         check(!busy && !sense_strobe, "R7", "stays idle",
               int'({busy, sense_strobe}), 0);
      end
      req_upper = 1'b0; ofs_a = '0; ofs_b = '0; ofs_c = '0;
   endtask

   task automatic t_reset;
      check(busy == 1'b0, "R1", "busy", int'(busy), 0);
      check(sense_strobe == 1'b0, "R1", "strobe", int'(sense_strobe), 0);
      check(done == 1'b0, "R1", "done", int'(done), 0);
      check(page_bits == '0, "R1", "page", int'(page_bits), 0);
   endtask

   task automatic t_lower_nominal;  set_vth(0);  run_read(1'b0, 0, 0, 0, 1'b0, "R2"); endtask
   task automatic t_upper_nominal;  set_vth(0);  run_read(1'b1, 0, 0, 0, 1'b0, "R3"); endtask
   task automatic t_lower_shifted;  set_vth(-6); run_read(1'b0, 0, -6, 0, 1'b0, "R4"); endtask
   task automatic t_upper_shifted;  set_vth(-6); run_read(1'b1, -6, 0, -6, 1'b0, "R4"); endtask
   task automatic t_lower_up;       set_vth(4);  run_read(1'b0, 0, 15, 0, 1'b0, "R4"); endtask
   task automatic t_saturate;       set_vth(0);  run_read(1'b1, -16, 0, 15, 1'b0, "R5"); endtask
   task automatic t_capture_lower;  set_vth(0);  run_read(1'b0, 3, -9, 2, 1'b1, "R6"); endtask
   task automatic t_capture_upper;  set_vth(-3); run_read(1'b1, -3, 4, -3, 1'b1, "R6"); endtask

   initial begin
      #(8 * 20000);
      fails++;
      $display("FAIL R10 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      set_vth(0);
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_lower_nominal;
      t_upper_nominal;
      t_lower_shifted;
      t_upper_shifted;
      t_lower_up;
      t_saturate;
      t_capture_lower;
      t_capture_upper;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule